// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a watchdog that catches runaway software. A free-running timebase counter advances on every system clock. The watchdog stays idle until software writes the control register for the first time. That write starts the watchdog and picks which counter bit paces it. The choice is fixed until the watchdog stops again.

Once armed, the watchdog sets a pending flag on every falling edge of the chosen counter bit. Software clears the flag by writing an ordered two-word key to the service register. If a falling edge arrives while the flag is still set, the block sends out a one-cycle request for a settings-initialization reset. The same edge returns the watchdog to its idle state. The watchdog stops only on a hard reset or after its own request, and only a new control write starts it again.

Top module: `keyed_watchdog`

## Requirements
- R1: The timebase counter is `CNT_W` bits wide (default 26). `rst_i` clears it to zero, it adds one on every clock after that, and it wraps. A falling edge of tap bit k happens when the counter moves from m·2^(k+1)−1 to m·2^(k+1).
- R2: After `rst_i`, the watchdog is inactive and `wdt_reset_o` stays low until the control register (address `CTRL_ADDR`, default 0) is written. Writes to the service register do not start it.
- R3: The first control write starts the watchdog. Bits 9:8 of that write pick the tap: code 0 selects `TAP0` (default 19), code 1 `TAP1` (21), code 2 `TAP2` (23) and code 3 `TAP3` (25).
- R4: While the watchdog is armed, further control writes change neither the tap nor anything else.
- R5: A write of 0x00A5 to the service register (address `KEY_ADDR`, default 1) opens the key. If the very next service write is 0x005A, the pending flag clears. A second 0x00A5 opens the key again. A word only counts as a key value when all of its upper bits are zero.
- R6: Any other service write after 0x00A5 cancels the open key. A 0x005A with no open key has no effect. Control writes and idle cycles between the two key words do not disturb the sequence.
- R7: While armed, the pending flag is set at the clock edge where the counter moves to m·2^(k+1)+1. If the flag was already set at that edge, `wdt_reset_o` is high for exactly the cycle in which the counter holds m·2^(k+1)+1.
- R8: The request lasts one cycle. The edge that raises it also disarms the watchdog and clears the pending flag and the key tracker, so no further request comes until the watchdog is re-armed.
- R9: After a request, a new control write re-arms the watchdog and its bits 9:8 set a new tap.
- R10: Asserting `rst_i` at any time stops the watchdog and restarts the counter from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System base clock |
| rst_i | input | 1 | Synchronous active-high hard reset |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| wr_addr_i | input | ADDR_W | Register address of the write |
| wr_data_i | input | DATA_W | Write data |
| wdt_reset_o | output | 1 | One-cycle settings-initialization reset request |

## Verification
The hardest case to reach from the ports is a key pair that is interrupted or that lands at one exact phase of the tap period. Whether the watchdog fires on the first or the second following edge depends on where the pair falls against the counter. The bench shrinks the taps to a few bits and counts clocks from the release of the hard reset. It places every control and key write at a chosen counter value, so each expected request cycle follows from the period arithmetic of R1 and R7. Broken, restarted and mixed-address key sequences then show up as a request one tap period earlier or later than an intact pair would give.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam int unsigned CODE_W   = 2;
    localparam int unsigned NUM_TAPS = 1 << CODE_W;

    localparam logic [7:0] KEY_OPEN  = 8'hA5;
    localparam logic [7:0] KEY_CLOSE = 8'h5A;

    typedef logic [CODE_W-1:0] ivl_code_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_HALF = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic ctrl_hit;
        logic key_hit;
    } wr_hit_t;

    typedef struct packed {
        logic      armed;
        logic      pending;
        ivl_code_t code;
    } guard_state_t;

    // True when the whole (zero-extended) word equals the key byte.
    function automatic logic word_is(input logic [31:0] word, input logic [7:0] key);
        return word == {24'd0, key};
    endfunction

endpackage

// File: rtl/kwd_timebase.sv
module kwd_timebase
    import kwd_pkg::*;
#(
    parameter int unsigned CNT_W = 26,
    parameter int unsigned TAP0  = 19,
    parameter int unsigned TAP1  = 21,
    parameter int unsigned TAP2  = 23,
    parameter int unsigned TAP3  = 25
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  ivl_code_t code_i,
    output logic      fall_o
);

    logic [CNT_W-1:0]    cnt_q;
    logic [NUM_TAPS-1:0] tap_vec;
    logic [NUM_TAPS-1:0] tap_vec_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q     <= '0;
            tap_vec_q <= '0;
        end else begin
            cnt_q     <= cnt_q + CNT_W'(1);
            tap_vec_q <= tap_vec;
        end
    end

    // Every candidate tap is registered, so a new code compares like with like.
    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int unsigned SEL = (g == 0) ? TAP0 :
                                      (g == 1) ? TAP1 :
                                      (g == 2) ? TAP2 : TAP3;
        assign tap_vec[g] = cnt_q[SEL];
    end

    assign fall_o = tap_vec_q[code_i] & ~tap_vec[code_i];

    // R1
    count_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> cnt_q == $past(cnt_q) + CNT_W'(1));

endmodule

// File: rtl/kwd_keyseq.sv
module kwd_keyseq
    import kwd_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              clr_i,
    input  logic              key_wr_i,
    input  logic [DATA_W-1:0] key_data_i,
    output logic              done_o
);

    seq_state_e st_q, st_d;
    logic       is_open, is_close;

    assign is_open  = word_is(32'(key_data_i), KEY_OPEN);
    assign is_close = word_is(32'(key_data_i), KEY_CLOSE);

    always_comb begin
        st_d   = st_q;
        done_o = 1'b0;
        if (key_wr_i) begin
            if (is_open) begin
                st_d = SEQ_HALF;
            end else begin
                done_o = (st_q == SEQ_HALF) && is_close;
                st_d   = SEQ_IDLE;
            end
        end
        if (clr_i) begin
            st_d = SEQ_IDLE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= SEQ_IDLE;
        else       st_q <= st_d;
    end

    // R5
    done_rewinds_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> st_q == SEQ_IDLE);

    // R6
    stray_cancels_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (key_wr_i && !is_open) |=> st_q == SEQ_IDLE);

endmodule

// File: rtl/kwd_guard.sv
module kwd_guard
    import kwd_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      arm_wr_i,
    input  ivl_code_t arm_code_i,
    input  logic      service_i,
    input  logic      fall_i,
    output ivl_code_t code_o,
    output logic      fire_o,
    output logic      seq_clr_o
);

    guard_state_t st_q, st_d;
    logic         fire_now;

    always_comb begin
        st_d     = st_q;
        fire_now = st_q.armed & fall_i & st_q.pending & ~service_i;
        if (fire_now) begin
            st_d.armed   = 1'b0;
            st_d.pending = 1'b0;
        end else begin
            if (st_q.armed && fall_i) begin
                st_d.pending = 1'b1;
            end else if (service_i) begin
                st_d.pending = 1'b0;
            end
            if (!st_q.armed && arm_wr_i) begin
                st_d.armed = 1'b1;
                st_d.code  = arm_code_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q   <= '0;
            fire_o <= 1'b0;
        end else begin
            st_q   <= st_d;
            fire_o <= fire_now;
        end
    end

    assign code_o    = st_q.code;
    assign seq_clr_o = fire_now;

    // R8
    single_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        fire_o |=> !fire_o);

    // R8
    disarm_after_fire_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        fire_o |-> (!st_q.armed && !st_q.pending));

    // R4
    code_locked_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.armed && $past(st_q.armed)) |-> $stable(st_q.code));

    // R2
    idle_silent_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(st_q.armed) |-> !fire_o);

    // R7
    fire_needs_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        fire_o |-> $past(st_q.pending));

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned CTRL_ADDR = 0,
    parameter int unsigned KEY_ADDR  = 1,
    parameter int unsigned CNT_W     = 26,
    parameter int unsigned TAP0      = 19,
    parameter int unsigned TAP1      = 21,
    parameter int unsigned TAP2      = 23,
    parameter int unsigned TAP3      = 25
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              wdt_reset_o
);

    localparam int unsigned CODE_LSB = 8;
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] KEY_A  = ADDR_W'(KEY_ADDR);

    wr_hit_t   hit;
    ivl_code_t wr_code;
    ivl_code_t cur_code;
    logic      fall;
    logic      service;
    logic      seq_clr;

    assign hit.ctrl_hit = wr_en_i && (wr_addr_i == CTRL_A);
    assign hit.key_hit  = wr_en_i && (wr_addr_i == KEY_A);
    assign wr_code      = ivl_code_t'(wr_data_i[CODE_LSB +: CODE_W]);

    kwd_timebase #(
        .CNT_W (CNT_W),
        .TAP0  (TAP0),
        .TAP1  (TAP1),
        .TAP2  (TAP2),
        .TAP3  (TAP3)
    ) u_timebase (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .code_i (cur_code),
        .fall_o (fall)
    );

    kwd_keyseq #(
        .DATA_W (DATA_W)
    ) u_keyseq (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .clr_i      (seq_clr),
        .key_wr_i   (hit.key_hit),
        .key_data_i (wr_data_i),
        .done_o     (service)
    );

    kwd_guard u_guard (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .arm_wr_i   (hit.ctrl_hit),
        .arm_code_i (wr_code),
        .service_i  (service),
        .fall_i     (fall),
        .code_o     (cur_code),
        .fire_o     (wdt_reset_o),
        .seq_clr_o  (seq_clr)
    );

endmodule

// File: tb/sim_keyed_watchdog.sv
module sim_keyed_watchdog;

    localparam int CLK_PERIOD = 10;
    localparam int CTRL_A     = 0;
    localparam int KEY_A      = 1;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        wdt_rst;

    int ncyc;
    int pulses, first_pulse, last_pulse, wide;
    logic prev_hi;
    int checks = 0;
    int fails  = 0;

    keyed_watchdog #(
        .ADDR_W (4), .DATA_W (16), .CTRL_ADDR (CTRL_A), .KEY_ADDR (KEY_A),
        .CNT_W (26), .TAP0 (3), .TAP1 (4), .TAP2 (5), .TAP3 (6)
    ) u0 (
        .clk_i (clk), .rst_i (rst), .wr_en_i (wr_en),
        .wr_addr_i (wr_addr), .wr_data_i (wr_data), .wdt_reset_o (wdt_rst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Clock count since the hard reset release, equal to the counter value (R1).
    always @(posedge clk) begin
        if (rst) ncyc <= 0;
        else     ncyc <= ncyc + 1;
    end

    always @(negedge clk) begin
        if (rst) begin
            pulses = 0; first_pulse = -1; last_pulse = -1; wide = 0; prev_hi = 1'b0;
        end else begin
            if (wdt_rst) begin
                if (pulses == 0) first_pulse = ncyc;
                last_pulse = ncyc;
                pulses++;
                if (prev_hi) wide++;
            end
            prev_hi = wdt_rst;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hard_reset();
        rst = 1'b1;
        wr_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_to(input int n);
        while (ncyc < n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1;
        wr_addr = 4'(a);
        wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R2: idle after reset, key writes alone do not start it
    task automatic t_idle();
        hard_reset();
        chk("R2 output low at reset", int'(wdt_rst), 0);
        wait_to(5);
        wr(KEY_A, 'hA5);
        wr(KEY_A, 'h5A);
        wait_to(300);
        chk("R2 no request while unarmed", pulses, 0);
    endtask

    // R1 R3 R7 R8: each code fires on the second edge of its tap
    task automatic t_code(input int code, input int exp);
        hard_reset();
        wait_to(2);
        wr(CTRL_A, code << 8);
        wait_to(exp + 100);
        chk($sformatf("R3 R7 code %0d request cycle", code), first_pulse, exp);
        chk("R8 single request and width", pulses * 10 + wide, 10);
    endtask

    // R4: a second control write cannot lengthen the interval
    task automatic t_locked();
        hard_reset();
        wait_to(2);
        wr(CTRL_A, 'h0000);
        wait_to(5);
        wr(CTRL_A, 'h0300);
        wait_to(100);
        chk("R4 rewrite ignored", first_pulse, 33);
    endtask

    // R5: regular servicing holds off the request
    task automatic t_service();
        hard_reset();
        wait_to(2);
        wr(CTRL_A, 'h0000);
        for (int k = 1; k <= 10; k++) begin
            wait_to(16 * k + 4);
            wr(KEY_A, 'hA5);
            wr(KEY_A, 'h5A);
        end
        wait_to(260);
        chk("R5 serviced until 165, request at 193", first_pulse, 193);
        chk("R5 one request", pulses, 1);
    endtask

    // Key pair variants placed after the first edge; expect 33 if void, 49 if valid
    task automatic t_pair(input string req, input int w0, input int a1, input int w1,
                          input int w2, input int exp);
        hard_reset();
        wait_to(2);
        wr(CTRL_A, 'h0000);
        wait_to(20);
        wr(KEY_A, w0);
        wr(a1, w1);
        if (w2 >= 0) wr(KEY_A, w2);
        wait_to(120);
        chk(req, first_pulse, exp);
    endtask

    // R8 R9: stays quiet after a request, then re-arms with a new code
    task automatic t_rearm();
        hard_reset();
        wait_to(2);
        wr(CTRL_A, 'h0000);
        wait_to(40);
        chk("R8 first request", first_pulse, 33);
        wait_to(300);
        chk("R8 no request after disarm", pulses, 1);
        hard_reset();
        wait_to(2);
        wr(CTRL_A, 'h0000);
        wait_to(40);
        wr(CTRL_A, 'h0100);
        wait_to(140);
        chk("R9 re-armed with code 1", last_pulse, 97);
        chk("R9 two requests", pulses, 2);
    endtask

    // R10: hard reset stops an armed watchdog
    task automatic t_stop();
        hard_reset();
        wait_to(2);
        wr(CTRL_A, 'h0000);
        wait_to(25);
        hard_reset();
        wait_to(300);
        chk("R10 stopped by hard reset", pulses, 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        t_idle();
        t_code(0, 33);
        t_code(1, 65);
        t_code(2, 129);
        t_code(3, 257);
        t_locked();
        t_service();
        // R5 valid pair clears the flag
        t_pair("R5 intact pair", 'hA5, KEY_A, 'h5A, -1, 49);
        // R5 reopened key still completes
        t_pair("R5 repeated open", 'hA5, KEY_A, 'hA5, 'h5A, 49);
        // R5 upper bits set is not a key word
        t_pair("R5 wide word", 'h01A5, KEY_A, 'h5A, -1, 33);
        // R6 foreign value cancels
        t_pair("R6 cancelled pair", 'hA5, KEY_A, 'h33, 'h5A, 33);
        // R6 lone close word
        t_pair("R6 lone close", 'h5A, KEY_A, 'h5A, -1, 33);
        // R6 control write between the key words
        t_pair("R6 control write between", 'hA5, CTRL_A, 'h0300, 'h5A, 49);
        t_rearm();
        t_stop();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule